// File: doc/BRIEF.md
# Wavefront Issue Sequencer for a 16-Lane SIMD

This block feeds one 16-lane vector datapath from a pool of up to ten resident wavefronts of 64 threads each. Every wavefront owns one instruction slot holding an instruction word, a double-precision flag and a 64-bit execute mask. A slot is filled through a load port and stays pending until the sequencer issues it. External dependency logic supplies a ready bit for each wavefront.

An issued instruction is shown to the lanes as four quarter-wavefront slices, one per clock. For each cycle the block drives the wavefront ID, the slice index and the 16 lane enables cut from that slice of the execute mask. Double-precision instructions hold each slice for a configurable number of clocks. The next wavefront is chosen round-robin in the last cycle of the current window, so issue windows run back to back. When nothing is eligible the block presents idle cycles with every lane dark.

Top module: `wis_issue_seq`

## Requirements
- R1: After reset no slot is pending and the outputs are idle (`iss_active`=0, `iss_lane_en`=0), even with every ready bit high.
- R2: A load (`ld_en`=1) into an empty slot makes it pending with the given instruction, mask and precision flag. A load into a slot that is still pending is ignored, and so is a load with `ld_wid` of 10 or more.
- R3: A single-precision instruction is issued over exactly 4 consecutive cycles with `iss_slice` = 0, 1, 2, 3. `iss_wid`, `iss_instr` and `iss_dp` stay constant, and `iss_last` is high only in the slice-3 cycle.
- R4: In the cycle that shows slice k, `iss_lane_en` equals execute-mask bits [16k+15:16k], where lane j corresponds to thread 16k+j.
- R5: A double-precision instruction (`iss_dp`=1) holds each slice for DP_FACTOR cycles (default 4), so its window lasts 4*DP_FACTOR cycles.
- R6: Selection is round-robin among wavefronts that are pending and ready. The search starts at the ID after the last one issued and wraps from 9 to 0. After reset the search starts at ID 0.
- R7: If an eligible wavefront exists in the last cycle of a window, its slice 0 appears in the very next cycle.
- R8: When no wavefront is eligible, `iss_active` is 0 and `iss_lane_en` is 0.
- R9: An all-zero execute mask still occupies its full window, with `iss_active`=1 and `iss_lane_en`=0 in every cycle.
- R10: A slot is freed at the end of its window. The same instruction is never issued twice, even if its ready bit stays high.
- R11: Ready is sampled only when a wavefront is selected. Dropping it during the window does not shorten or stop the issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load an instruction into a slot |
| ld_wid | input | 4 | Slot (wavefront ID) to load |
| ld_instr | input | 32 | Instruction word to store |
| ld_dp | input | 1 | Instruction is double precision |
| ld_mask | input | 64 | Execute mask, one bit per thread |
| wave_ready | input | 10 | Per-wavefront ready from dependency logic |
| iss_active | output | 1 | A slice is being issued this cycle |
| iss_wid | output | 4 | Wavefront ID being issued |
| iss_slice | output | 2 | Quarter-wavefront index |
| iss_lane_en | output | 16 | Lane enables for this slice |
| iss_instr | output | 32 | Instruction word being issued |
| iss_dp | output | 1 | Issued instruction is double precision |
| iss_last | output | 1 | Final cycle of the issue window |

## Verification
The hardest case to reach is a hand-over at the window boundary. Several wavefronts must be waiting at once so that the round-robin pointer, the freeing of the current slot and the back-to-back start all take effect on one edge. The stimulus reaches it by loading several slots while every ready bit is held low, then raising the ready bits together. Three windows then chain with no idle cycle, and the wrap order starts after the previously issued ID. Each table entry also drops its ready bit as soon as its window opens, which shows that a running issue is not interrupted.

// File: rtl/wis_pkg.sv
package wis_pkg;

    localparam int LANES   = 16;
    localparam int THREADS = 64;
    localparam int INSTR_W = 32;
    localparam int SLICES  = THREADS / LANES;
    localparam int SLICE_W = (SLICES > 1) ? $clog2(SLICES) : 1;

    typedef logic [THREADS-1:0] exec_mask_t;
    typedef logic [LANES-1:0]   lane_en_t;
    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [SLICE_W-1:0] slice_idx_t;

    // Contents of one wavefront instruction slot
    typedef struct packed {
        instr_t     instr;
        logic       dp;
        exec_mask_t mask;
    } slot_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    // Lane enables for quarter s: threads s*LANES .. s*LANES+LANES-1
    function automatic lane_en_t slice_lanes(input exec_mask_t m, input slice_idx_t s);
        return m[int'(s)*LANES +: LANES];
    endfunction

endpackage

// File: rtl/wis_slot_bank.sv
module wis_slot_bank
    import wis_pkg::*;
#(
    parameter int NUM_WAVES = 10,
    parameter int WID_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WID_W-1:0]     wr_wid,
    input  slot_t                wr_data,
    input  logic                 clr_en,
    input  logic [WID_W-1:0]     clr_wid,
    input  logic [WID_W-1:0]     rd_wid,
    output logic [NUM_WAVES-1:0] pending,
    output slot_t                rd_data
);

    localparam logic [WID_W-1:0] TOP_WID = WID_W'(NUM_WAVES - 1);

    slot_t [NUM_WAVES-1:0] slot_arr;

    for (genvar i = 0; i < NUM_WAVES; i++) begin : g_slot
        logic  vld_q;
        slot_t data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                data_q <= '0;
            end else if (clr_en && clr_wid == WID_W'(i)) begin
                vld_q <= 1'b0;
            end else if (wr_en && wr_wid == WID_W'(i) && !vld_q) begin
                vld_q  <= 1'b1;
                data_q <= wr_data;
            end
        end

        assign pending[i]  = vld_q;
        assign slot_arr[i] = data_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_wid <= TOP_WID) begin
            rd_data = slot_arr[rd_wid];
        end
    end

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WAVES = 10,
    parameter int WID_W     = 4
) (
    input  logic [NUM_WAVES-1:0] req,
    input  logic [WID_W-1:0]     prev_wid,
    output logic                 gnt_vld,
    output logic [WID_W-1:0]     gnt_wid
);

    // Search order: prev+1, prev+2, ... wrapping, prev last
    always_comb begin
        gnt_vld = 1'b0;
        gnt_wid = prev_wid;
        for (int off = 1; off <= NUM_WAVES; off++) begin
            int idx;
            idx = int'(prev_wid) + off;
            if (idx >= NUM_WAVES) begin
                idx = idx - NUM_WAVES;
            end
            if (!gnt_vld && req[idx]) begin
                gnt_vld = 1'b1;
                gnt_wid = WID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/wis_window.sv
module wis_window
    import wis_pkg::*;
#(
    parameter int DP_FACTOR = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_dp,
    output logic       busy,
    output slice_idx_t slice,
    output logic       last
);

    localparam int REP_W = (DP_FACTOR > 1) ? $clog2(DP_FACTOR) : 1;
    localparam logic [REP_W-1:0] REP_MAX = REP_W'(DP_FACTOR - 1);
    localparam slice_idx_t       SL_MAX  = SLICE_W'(SLICES - 1);

    seq_state_e       state_q;
    slice_idx_t       slice_q;
    logic [REP_W-1:0] rep_q;
    logic             dp_q;
    logic [REP_W-1:0] rep_lim;
    logic             rep_done;

    assign rep_lim  = dp_q ? REP_MAX : '0;
    assign rep_done = (rep_q == rep_lim);
    assign busy     = (state_q == SEQ_BUSY);
    assign slice    = slice_q;
    assign last     = busy && rep_done && (slice_q == SL_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            slice_q <= '0;
            rep_q   <= '0;
            dp_q    <= 1'b0;
        end else if (start) begin
            state_q <= SEQ_BUSY;
            slice_q <= '0;
            rep_q   <= '0;
            dp_q    <= start_dp;
        end else if (last) begin
            state_q <= SEQ_IDLE;
            slice_q <= '0;
            rep_q   <= '0;
        end else if (busy) begin
            if (rep_done) begin
                rep_q   <= '0;
                slice_q <= slice_q + 1'b1;
            end else begin
                rep_q <= rep_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wis_issue_seq.sv
module wis_issue_seq
    import wis_pkg::*;
#(
    parameter  int NUM_WAVES = 10,
    parameter  int DP_FACTOR = 4,
    localparam int WID_W     = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_en,
    input  logic [WID_W-1:0]     ld_wid,
    input  logic [INSTR_W-1:0]   ld_instr,
    input  logic                 ld_dp,
    input  logic [THREADS-1:0]   ld_mask,
    input  logic [NUM_WAVES-1:0] wave_ready,
    output logic                 iss_active,
    output logic [WID_W-1:0]     iss_wid,
    output logic [SLICE_W-1:0]   iss_slice,
    output logic [LANES-1:0]     iss_lane_en,
    output logic [INSTR_W-1:0]   iss_instr,
    output logic                 iss_dp,
    output logic                 iss_last
);

    localparam logic [WID_W-1:0] TOP_WID = WID_W'(NUM_WAVES - 1);

    logic [NUM_WAVES-1:0] pending;
    logic [NUM_WAVES-1:0] cur_hold;
    logic [NUM_WAVES-1:0] eligible;
    logic                 wr_ok;
    slot_t                wr_slot;
    slot_t                pick_slot;
    slot_t                cur_q;
    logic [WID_W-1:0]     cur_wid_q;
    logic                 gnt_vld;
    logic [WID_W-1:0]     gnt_wid;
    logic                 busy;
    logic                 last;
    logic                 start;
    slice_idx_t           slice;

    assign wr_ok   = ld_en && (ld_wid <= TOP_WID);
    assign wr_slot = '{instr: ld_instr, dp: ld_dp, mask: ld_mask};

    wis_slot_bank #(
        .NUM_WAVES(NUM_WAVES),
        .WID_W    (WID_W)
    ) bank_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ok),
        .wr_wid (ld_wid),
        .wr_data(wr_slot),
        .clr_en (last),
        .clr_wid(cur_wid_q),
        .rd_wid (gnt_wid),
        .pending(pending),
        .rd_data(pick_slot)
    );

    // The wave being issued is being freed; keep it out of the search
    for (genvar i = 0; i < NUM_WAVES; i++) begin : g_hold
        assign cur_hold[i] = busy && (cur_wid_q == WID_W'(i));
    end

    assign eligible = pending & wave_ready & ~cur_hold;

    wis_rr_pick #(
        .NUM_WAVES(NUM_WAVES),
        .WID_W    (WID_W)
    ) pick_i (
        .req     (eligible),
        .prev_wid(cur_wid_q),
        .gnt_vld (gnt_vld),
        .gnt_wid (gnt_wid)
    );

    assign start = (!busy || last) && gnt_vld;

    wis_window #(
        .DP_FACTOR(DP_FACTOR)
    ) win_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .start_dp(pick_slot.dp),
        .busy    (busy),
        .slice   (slice),
        .last    (last)
    );

    // cur_wid_q doubles as the round-robin pointer (last issued ID)
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_wid_q <= TOP_WID;
            cur_q     <= '0;
        end else if (start) begin
            cur_wid_q <= gnt_wid;
            cur_q     <= pick_slot;
        end
    end

    assign iss_active  = busy;
    assign iss_wid     = cur_wid_q;
    assign iss_slice   = slice;
    assign iss_lane_en = busy ? slice_lanes(cur_q.mask, slice) : '0;
    assign iss_instr   = cur_q.instr;
    assign iss_dp      = cur_q.dp;
    assign iss_last    = last;

endmodule

// File: rtl/wis_issue_chk.sv
module wis_issue_chk
    import wis_pkg::*;
#(
    parameter int DP_FACTOR = 4,
    parameter int WID_W     = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               iss_active,
    input logic [WID_W-1:0]   iss_wid,
    input logic [SLICE_W-1:0] iss_slice,
    input logic [LANES-1:0]   iss_lane_en,
    input logic [INSTR_W-1:0] iss_instr,
    input logic               iss_dp,
    input logic               iss_last
);

    localparam int CNT_W = $clog2(DP_FACTOR * SLICES) + 1;
    localparam logic [CNT_W-1:0] SP_END = CNT_W'(SLICES - 1);
    localparam logic [CNT_W-1:0] DP_END = CNT_W'(DP_FACTOR * SLICES - 1);

    logic [CNT_W-1:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
        end else if (iss_active && !iss_last) begin
            win_cnt <= win_cnt + 1'b1;
        end else begin
            win_cnt <= '0;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!iss_active && iss_lane_en == '0));

    p_idle_dark_r8: assert property (@(posedge clk) disable iff (rst)
        !iss_active |-> (iss_lane_en == '0));

    p_hold_wave_r3: assert property (@(posedge clk) disable iff (rst)
        (iss_active && !iss_last) |=>
            (iss_active && $stable(iss_wid) && $stable(iss_instr) && $stable(iss_dp)));

    p_sp_step_r3: assert property (@(posedge clk) disable iff (rst)
        (iss_active && !iss_dp && !iss_last) |=>
            (iss_slice == SLICE_W'($past(iss_slice) + 1'b1)));

    p_end_slice_r3: assert property (@(posedge clk) disable iff (rst)
        iss_last |-> (iss_active && iss_slice == SLICE_W'(SLICES - 1)));

    p_dp_step_r5: assert property (@(posedge clk) disable iff (rst)
        (iss_active && iss_dp && !iss_last) |=>
            (iss_slice == $past(iss_slice) || iss_slice == SLICE_W'($past(iss_slice) + 1'b1)));

    p_window_len_r5: assert property (@(posedge clk) disable iff (rst)
        iss_last |-> (win_cnt == (iss_dp ? DP_END : SP_END)));

    p_next_slice0_r7: assert property (@(posedge clk) disable iff (rst)
        iss_last |=> (!iss_active || iss_slice == '0));

endmodule

bind wis_issue_seq wis_issue_chk #(
    .DP_FACTOR(DP_FACTOR),
    .WID_W    (WID_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .iss_active (iss_active),
    .iss_wid    (iss_wid),
    .iss_slice  (iss_slice),
    .iss_lane_en(iss_lane_en),
    .iss_instr  (iss_instr),
    .iss_dp     (iss_dp),
    .iss_last   (iss_last)
);

// File: tb/wis_issue_seq_tb_top.sv
module wis_issue_seq_tb_top;

    localparam int NW  = 10;
    localparam int DPF = 4;

    typedef struct packed {
        logic [3:0]  wid;
        logic        dp;
        logic [63:0] mask;
        logic [31:0] instr;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, 64'hFFFF_0000_00FF_8001, 32'h1000_0001},
        '{4'd9, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h2000_0009},
        '{4'd4, 1'b0, 64'h0000_0000_0000_0000, 32'h3000_0004},
        '{4'd6, 1'b1, 64'h0123_4567_89AB_CDEF, 32'h4000_0006},
        '{4'd1, 1'b0, 64'h8000_0000_0000_0001, 32'h5000_0001},
        '{4'd7, 1'b1, 64'h0000_0000_0000_0000, 32'h6000_0007}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [3:0]    ld_wid = '0;
    logic [31:0]   ld_instr = '0;
    logic          ld_dp = 1'b0;
    logic [63:0]   ld_mask = '0;
    logic [NW-1:0] wave_ready = '0;
    logic          iss_active;
    logic [3:0]    iss_wid;
    logic [1:0]    iss_slice;
    logic [15:0]   iss_lane_en;
    logic [31:0]   iss_instr;
    logic          iss_dp;
    logic          iss_last;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wis_issue_seq #(.NUM_WAVES(NW), .DP_FACTOR(DPF)) dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_wid(ld_wid), .ld_instr(ld_instr),
        .ld_dp(ld_dp), .ld_mask(ld_mask), .wave_ready(wave_ready),
        .iss_active(iss_active), .iss_wid(iss_wid), .iss_slice(iss_slice),
        .iss_lane_en(iss_lane_en), .iss_instr(iss_instr), .iss_dp(iss_dp),
        .iss_last(iss_last)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] w, input logic d, input logic [63:0] m, input logic [31:0] ins);
        @(negedge clk);
        ld_en = 1'b1; ld_wid = w; ld_dp = d; ld_mask = m; ld_instr = ins;
    endtask

    task automatic wait_active(input string req);
        int k = 0;
        while (!iss_active && k < 30) begin
            @(negedge clk);
            k++;
        end
        check({req, " window starts"}, 64'(iss_active), 64'd1);
    endtask

    // Check a full window that is already visible at the current negedge
    task automatic check_window(input vec_t v, input bit drop_ready);
        int len = v.dp ? 4 * DPF : 4;
        for (int c = 0; c < len; c++) begin
            int sl = v.dp ? c / DPF : c;
            if (c == 0 && drop_ready) wave_ready = '0;  // R11: ready dropped mid-window
            check("R3 active", 64'(iss_active), 64'd1);
            check("R3 wid", 64'(iss_wid), 64'(v.wid));
            check("R3 instr", 64'(iss_instr), 64'(v.instr));
            check("R5 slice", 64'(iss_slice), 64'(sl));
            check("R4 lane_en", 64'(iss_lane_en), 64'(v.mask[sl*16 +: 16]));
            check("R3 last", 64'(iss_last), 64'(c == len - 1));
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        vec_t ra, rb;
        vec_t rr_exp [3];
        // R1: reset with all ready high, nothing pending
        wave_ready = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 idle after reset", 64'(iss_active), 64'd0);
            check("R1 lanes dark", 64'(iss_lane_en), 64'd0);
        end
        wave_ready = '0;

        // Table walk: R3 R4 R5 R9 R11, then R8 idle
        for (int i = 0; i < NV; i++) begin
            load(VECS[i].wid, VECS[i].dp, VECS[i].mask, VECS[i].instr);
            wave_ready[VECS[i].wid] = 1'b1;
            @(negedge clk);
            ld_en = 1'b0;
            wait_active("R6");
            check("R5 dp flag", 64'(iss_dp), 64'(VECS[i].dp));
            check_window(VECS[i], 1'b1);
            check("R8 idle active", 64'(iss_active), 64'd0);
            check("R8 idle lanes", 64'(iss_lane_en), 64'd0);
        end

        // R2: second load to pending slot and out-of-range load ignored
        ra = '{4'd3, 1'b0, 64'hAAAA_5555_F0F0_0F0F, 32'hA0A0_0003};
        rb = '{4'd3, 1'b0, 64'h1111_2222_3333_4444, 32'hBBBB_0003};
        load(ra.wid, ra.dp, ra.mask, ra.instr);
        load(rb.wid, rb.dp, rb.mask, rb.instr);
        load(4'd12, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF, 32'hCCCC_000C);
        @(negedge clk);
        ld_en = 1'b0;
        wave_ready = '1;
        wait_active("R2");
        check("R2 first load kept", 64'(iss_instr), 64'(ra.instr));
        check_window(ra, 1'b0);
        // R10: ready still high, slot freed, no reissue; R2: wid 12 never issues
        for (int i = 0; i < 4; i++) begin
            check("R10 no reissue", 64'(iss_active), 64'd0);
            @(negedge clk);
        end
        wave_ready = '0;

        // R6 R7: three waves pending, released together; last issued was 3
        load(4'd2, 1'b0, 64'h0000_0000_0000_FFFF, 32'h7000_0002);
        load(4'd5, 1'b0, 64'hFFFF_0000_0000_0000, 32'h7000_0005);
        load(4'd7, 1'b0, 64'h00FF_00FF_00FF_00FF, 32'h7000_0007);
        @(negedge clk);
        ld_en = 1'b0;
        wave_ready = 10'b00_1010_0100;
        rr_exp[0] = '{4'd5, 1'b0, 64'hFFFF_0000_0000_0000, 32'h7000_0005};
        rr_exp[1] = '{4'd7, 1'b0, 64'h00FF_00FF_00FF_00FF, 32'h7000_0007};
        rr_exp[2] = '{4'd2, 1'b0, 64'h0000_0000_0000_FFFF, 32'h7000_0002};
        wait_active("R6");
        for (int j = 0; j < 3; j++) begin
            check("R7 back-to-back", 64'(iss_active), 64'd1);
            check("R6 rr order", 64'(iss_wid), 64'(rr_exp[j].wid));
            check_window(rr_exp[j], 1'b0);
        end
        check("R8 idle after drain", 64'(iss_active), 64'd0);
        check("R8 lanes dark", 64'(iss_lane_en), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule